// File: doc/BRIEF.md
# Flash Status-Read and Write-Enable Command Sequencer

This block runs two fixed single-byte flash commands without software touching the serial data path. A write to the command register asks for either a status-register read or a write-enable, or both, on one of several flash banks. The sequencer hands each opcode and its bank to the shared serial shift engine. It waits for the engine to report completion and then updates the controller status word.

A status read copies the byte returned by the flash into the low byte of the status word. A write enable sets a per-bank write-mode bit in the upper status bits. When either command finishes, a transfer-finished flag is raised. The interrupt output follows the transfer-finished and write-complete flags, each gated by its own enable bit in the command register. Software clears flags by writing a mask to the status word. The memory-mapped write path reports the end of a write burst, which clears that bank's write-mode bit, and reports a completed write, which sets the write-complete flag.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the status word is zero, `irq` is low and `eng_req` is low.
- R2: A command-register write with bit 10 set requests opcode 0x05 from the engine for the bank in bits [13:12]; on completion the returned byte appears in status bits [7:0].
- R3: A command-register write with bit 11 set requests opcode 0x06 for the bank in bits [13:12]; on completion status bit 12 plus the bank number is set and status bits [7:0] keep their value.
- R4: Completion of either command sets status bit 8 (transfer finished).
- R5: When bits 10 and 11 are set in the same write, the status read is requested first and the write enable second, both to the same bank.
- R6: A command-register write that arrives while a command is pending or in flight starts nothing: no engine request follows and the status word is unchanged by it.
- R7: A status-register write clears every status bit whose written data bit is 0 and keeps the others; writing zero clears the whole word.
- R8: `irq` is high exactly when (status bit 8 and command bit 8) or (status bit 9 and command bit 9) hold, with the enable bits taken from the last command-register write.
- R9: A one-cycle `wr_done` pulse sets status bit 9 (write complete).
- R10: A one-cycle `burst_end` pulse clears the write-mode bit of the bank on `burst_bank` and leaves the other banks' bits alone.
- R11: `eng_req` is a one-cycle pulse, and no new request is made until the engine has answered the previous one with `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe of the command register |
| ctl_wdata | input | 16 | Command data: [8] transfer-finished irq enable, [9] write-complete irq enable, [10] status read, [11] write enable, [13:12] bank |
| sts_wr | input | 1 | Write strobe of the status word (AND mask) |
| sts_wdata | input | 16 | Status write mask |
| status | output | 16 | [7:0] flash status byte, [8] transfer finished, [9] write complete, [15:12] per-bank write mode |
| irq | output | 1 | Interrupt request |
| wr_done | input | 1 | Pulse: a memory-mapped write has completed |
| burst_end | input | 1 | Pulse: a memory-mapped write burst has ended |
| burst_bank | input | 2 | Bank of the ended burst |
| eng_req | output | 1 | Request pulse to the shared shift engine |
| eng_op | output | 8 | Opcode for the engine, valid with `eng_req` |
| eng_bank | output | 2 | Bank select for the engine, valid with `eng_req` |
| eng_done | input | 1 | Engine completion pulse |
| eng_rx | input | 8 | Byte received by the engine, valid with `eng_done` |

## Verification
The assertions assume the shift engine answers each request with exactly one `eng_done` pulse and never raises `eng_done` when nothing is outstanding. They also assume no `burst_end` arrives for a bank in the same cycle that a write enable to that bank completes. The bench's engine model answers only requests it has been told to expect, after a fixed latency. It drives burst and write-done pulses only while the sequencer is idle, so the stimulus stays inside those assumptions.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  // command register fields
  localparam int TFIE_BIT     = 8;
  localparam int WCIE_BIT     = 9;
  localparam int RDSR_REQ_BIT = 10;
  localparam int WREN_REQ_BIT = 11;
  localparam int BANK_LSB     = 12;
  // status word fields
  localparam int BYTE_W       = 8;
  localparam int TFF_BIT      = 8;
  localparam int WCF_BIT      = 9;
  localparam int WM_LSB       = 12;

  typedef enum logic {ST_IDLE, ST_WAIT} seq_state_e;
  typedef enum logic {CMD_RDSR, CMD_WREN} cmd_kind_e;
endpackage

// File: rtl/fcs_ctl.sv
module fcs_ctl
  import fcs_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [REG_W-1:0]  ctl_wdata,
  input  logic              seq_busy,
  input  logic              launch_rd,
  input  logic              launch_we,
  output logic              pend_rd,
  output logic              pend_we,
  output logic [BANK_W-1:0] req_bank,
  output logic              tfie,
  output logic              wcie
);
  logic              pend_rd_d, pend_we_d, tfie_d, wcie_d;
  logic [BANK_W-1:0] bank_d;
  logic              accept;
  logic              reg_en;

  assign accept = ctl_wr && !seq_busy && !pend_rd && !pend_we;
  assign reg_en = ctl_wr || launch_rd || launch_we;

  always_comb begin
    pend_rd_d = pend_rd;
    pend_we_d = pend_we;
    bank_d    = req_bank;
    tfie_d    = tfie;
    wcie_d    = wcie;
    if (ctl_wr) begin
      tfie_d = ctl_wdata[TFIE_BIT];
      wcie_d = ctl_wdata[WCIE_BIT];
    end
    if (accept) begin
      pend_rd_d = ctl_wdata[RDSR_REQ_BIT];
      pend_we_d = ctl_wdata[WREN_REQ_BIT];
      bank_d    = ctl_wdata[BANK_LSB +: BANK_W];
    end else begin
      if (launch_rd) pend_rd_d = 1'b0;
      if (launch_we) pend_we_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_rd  <= 1'b0;
      pend_we  <= 1'b0;
      req_bank <= '0;
      tfie     <= 1'b0;
      wcie     <= 1'b0;
    end else if (reg_en) begin
      pend_rd  <= pend_rd_d;
      pend_we  <= pend_we_d;
      req_bank <= bank_d;
      tfie     <= tfie_d;
      wcie     <= wcie_d;
    end
  end

  logic unused_ctl_bits;
  assign unused_ctl_bits = ^{ctl_wdata[TFIE_BIT-1:0], ctl_wdata[REG_W-1:BANK_LSB+BANK_W]};
endmodule

// File: rtl/fcs_fsm.sv
module fcs_fsm
  import fcs_pkg::*;
#(
  parameter int          BANK_W  = 2,
  parameter logic [7:0]  OP_RDSR = 8'h05,
  parameter logic [7:0]  OP_WREN = 8'h06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_rd,
  input  logic              pend_we,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              eng_done,
  output logic              launch_rd,
  output logic              launch_we,
  output logic              seq_busy,
  output logic              eng_req,
  output logic [7:0]        eng_op,
  output logic [BANK_W-1:0] eng_bank,
  output logic              cmp_valid,
  output cmd_kind_e         cmp_kind
);
  seq_state_e        state_q, state_d;
  cmd_kind_e         kind_q, kind_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              req_q, req_d;
  logic              launch;

  // status read has priority over write enable when both are pending
  assign launch_rd = (state_q == ST_IDLE) && pend_rd;
  assign launch_we = (state_q == ST_IDLE) && !pend_rd && pend_we;
  assign launch    = launch_rd || launch_we;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    bank_d  = bank_q;
    req_d   = launch;
    case (state_q)
      ST_IDLE: if (launch) begin
        state_d = ST_WAIT;
        kind_d  = launch_rd ? CMD_RDSR : CMD_WREN;
        bank_d  = req_bank;
      end
      ST_WAIT: if (eng_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= CMD_RDSR;
      bank_q  <= '0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      if (launch) begin
        kind_q <= kind_d;
        bank_q <= bank_d;
      end
    end
  end

  assign seq_busy  = (state_q == ST_WAIT);
  assign eng_req   = req_q;
  assign eng_op    = (kind_q == CMD_RDSR) ? OP_RDSR : OP_WREN;
  assign eng_bank  = bank_q;
  assign cmp_valid = seq_busy && eng_done;
  assign cmp_kind  = kind_q;
endmodule

// File: rtl/fcs_status.sv
module fcs_status
  import fcs_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int REG_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sts_wr,
  input  logic [REG_W-1:0]  sts_wdata,
  input  logic              wr_done,
  input  logic              burst_end,
  input  logic [BANK_W-1:0] burst_bank,
  input  logic              cmp_valid,
  input  cmd_kind_e         cmp_kind,
  input  logic [BANK_W-1:0] cmp_bank,
  input  logic [BYTE_W-1:0] cmp_rx,
  input  logic              tfie,
  input  logic              wcie,
  output logic [REG_W-1:0]  status,
  output logic              irq
);
  logic [REG_W-1:0] sts_q, sts_d;
  logic             sts_en;

  assign sts_en = sts_wr || wr_done || burst_end || cmp_valid;

  always_comb begin
    sts_d = sts_q;
    if (sts_wr) sts_d = sts_q & sts_wdata;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (burst_end && (burst_bank == BANK_W'(b))) sts_d[WM_LSB+b] = 1'b0;
    end
    if (wr_done) sts_d[WCF_BIT] = 1'b1;
    if (cmp_valid) begin
      sts_d[TFF_BIT] = 1'b1;
      if (cmp_kind == CMD_RDSR) begin
        sts_d[BYTE_W-1:0] = cmp_rx;
      end else begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (cmp_bank == BANK_W'(b)) sts_d[WM_LSB+b] = 1'b1;
        end
      end
    end
    sts_d[WM_LSB-1:WCF_BIT+1] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_d;
  end

  assign status = sts_q;
  assign irq    = (sts_q[TFF_BIT] && tfie) || (sts_q[WCF_BIT] && wcie);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int         NUM_BANKS = 4,
  parameter logic [7:0] OP_RDSR   = 8'h05,
  parameter logic [7:0] OP_WREN   = 8'h06,
  localparam int        BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int        REG_W     = WM_LSB + NUM_BANKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [REG_W-1:0]  ctl_wdata,
  input  logic              sts_wr,
  input  logic [REG_W-1:0]  sts_wdata,
  output logic [REG_W-1:0]  status,
  output logic              irq,
  input  logic              wr_done,
  input  logic              burst_end,
  input  logic [BANK_W-1:0] burst_bank,
  output logic              eng_req,
  output logic [7:0]        eng_op,
  output logic [BANK_W-1:0] eng_bank,
  input  logic              eng_done,
  input  logic [7:0]        eng_rx
);
  // reset asserts at once, releases on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic              pend_rd, pend_we, launch_rd, launch_we, seq_busy;
  logic              tfie, wcie, cmp_valid;
  logic [BANK_W-1:0] req_bank;
  cmd_kind_e         cmp_kind;

  fcs_ctl #(.BANK_W(BANK_W), .REG_W(REG_W)) u_ctl (
    .clk(clk), .rst_n(rst_sync_n),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .seq_busy(seq_busy), .launch_rd(launch_rd), .launch_we(launch_we),
    .pend_rd(pend_rd), .pend_we(pend_we), .req_bank(req_bank),
    .tfie(tfie), .wcie(wcie)
  );

  fcs_fsm #(.BANK_W(BANK_W), .OP_RDSR(OP_RDSR), .OP_WREN(OP_WREN)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .pend_rd(pend_rd), .pend_we(pend_we), .req_bank(req_bank),
    .eng_done(eng_done),
    .launch_rd(launch_rd), .launch_we(launch_we), .seq_busy(seq_busy),
    .eng_req(eng_req), .eng_op(eng_op), .eng_bank(eng_bank),
    .cmp_valid(cmp_valid), .cmp_kind(cmp_kind)
  );

  fcs_status #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .REG_W(REG_W)) u_sts (
    .clk(clk), .rst_n(rst_sync_n),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .wr_done(wr_done), .burst_end(burst_end), .burst_bank(burst_bank),
    .cmp_valid(cmp_valid), .cmp_kind(cmp_kind), .cmp_bank(eng_bank),
    .cmp_rx(eng_rx), .tfie(tfie), .wcie(wcie),
    .status(status), .irq(irq)
  );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import fcs_pkg::*;
#(
  parameter int         NUM_BANKS = 4,
  parameter logic [7:0] OP_RDSR   = 8'h05,
  parameter logic [7:0] OP_WREN   = 8'h06,
  localparam int        BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int        REG_W     = WM_LSB + NUM_BANKS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eng_req,
  input logic [7:0]        eng_op,
  input logic [BANK_W-1:0] eng_bank,
  input logic              eng_done,
  input logic [7:0]        eng_rx,
  input logic              burst_end,
  input logic [BANK_W-1:0] burst_bank,
  input logic [REG_W-1:0]  status
);
  logic              out_q;
  logic [7:0]        op_q;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      op_q   <= '0;
      bank_q <= '0;
    end else if (eng_req) begin
      out_q  <= 1'b1;
      op_q   <= eng_op;
      bank_q <= eng_bank;
    end else if (eng_done) begin
      out_q  <= 1'b0;
    end
  end

  logic rd_fin, we_fin;
  assign rd_fin = out_q && eng_done && (op_q == OP_RDSR);
  assign we_fin = out_q && eng_done && (op_q == OP_WREN);

  assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> !eng_req);

  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |-> !eng_req);

  assert_status_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fin |=> (status[BYTE_W-1:0] == $past(eng_rx)));

  assert_wm_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we_fin |=> status[WM_LSB + int'($past(bank_q))]);

  assert_tff_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fin || we_fin) |=> status[TFF_BIT]);

  assert_wm_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && !(we_fin && bank_q == burst_bank))
      |=> !status[WM_LSB + int'($past(burst_bank))]);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .NUM_BANKS(NUM_BANKS), .OP_RDSR(OP_RDSR), .OP_WREN(OP_WREN)
) u_chk (.*);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ENG_LAT    = 5;

  typedef struct packed {
    logic [7:0] op;
    logic [1:0] bank;
    logic [7:0] rx;
  } eng_item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr, sts_wr, wr_done, burst_end, eng_done;
  logic [15:0] ctl_wdata, sts_wdata, status;
  logic [1:0]  burst_bank, eng_bank;
  logic [7:0]  eng_op, eng_rx;
  logic        irq, eng_req;

  flash_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .status(status), .irq(irq),
    .wr_done(wr_done), .burst_end(burst_end), .burst_bank(burst_bank),
    .eng_req(eng_req), .eng_op(eng_op), .eng_bank(eng_bank),
    .eng_done(eng_done), .eng_rx(eng_rx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int          n_chk = 0;
  int          n_fail = 0;
  logic [15:0] exp_sts = '0;
  logic        tfie_m = 1'b0;
  logic        wcie_m = 1'b0;
  eng_item_t   eng_q[$];
  logic [15:0] sts_exp_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic exp_irq(input logic [15:0] s);
    return (s[8] & tfie_m) | (s[9] & wcie_m);
  endfunction

  task automatic ctl_write(input logic [15:0] d);
    @(posedge clk); #1;
    ctl_wr = 1'b1; ctl_wdata = d;
    @(posedge clk); #1;
    ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  // driver: pushes expected engine requests and status values, then writes
  task automatic issue(input logic rd, input logic we, input logic [1:0] b,
                       input logic [7:0] rx, input logic te, input logic ce);
    tfie_m = te;
    wcie_m = ce;
    if (rd) begin
      eng_q.push_back('{op: 8'h05, bank: b, rx: rx});
      exp_sts[7:0] = rx;
      exp_sts[8]   = 1'b1;
      sts_exp_q.push_back(exp_sts);
    end
    if (we) begin
      eng_q.push_back('{op: 8'h06, bank: b, rx: 8'h3C});
      exp_sts[12 + int'(b)] = 1'b1;
      exp_sts[8]            = 1'b1;
      sts_exp_q.push_back(exp_sts);
    end
    ctl_write({2'b00, b, we, rd, ce, te, 8'h00});
  endtask

  task automatic wait_idle;
    while (eng_q.size() != 0 || sts_exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic sts_write(input logic [15:0] m);
    @(posedge clk); #1;
    sts_wr = 1'b1; sts_wdata = m;
    @(posedge clk); #1;
    sts_wr = 1'b0; sts_wdata = '0;
    exp_sts = exp_sts & m;
  endtask

  task automatic pulse_burst_end(input logic [1:0] b);
    @(posedge clk); #1;
    burst_end = 1'b1; burst_bank = b;
    @(posedge clk); #1;
    burst_end = 1'b0; burst_bank = '0;
    exp_sts[12 + int'(b)] = 1'b0;
  endtask

  task automatic pulse_wr_done;
    @(posedge clk); #1;
    wr_done = 1'b1;
    @(posedge clk); #1;
    wr_done = 1'b0;
    exp_sts[9] = 1'b1;
  endtask

  task automatic check_now(input string tag);
    @(negedge clk);
    chk({tag, " status"}, 32'(status), 32'(exp_sts));
    chk({tag, " irq"}, 32'(irq), 32'(exp_irq(exp_sts)));
  endtask

  // engine model: checks each request against the expected queue
  initial begin
    eng_item_t it;
    eng_done = 1'b0;
    eng_rx   = '0;
    forever begin
      @(negedge clk);
      if (eng_req === 1'b1) begin
        if (eng_q.size() == 0) begin
          chk("R6 request with none expected", 32'd1, 32'd0);
        end else begin
          it = eng_q.pop_front();
          chk((it.op == 8'h05) ? "R2 R5 opcode" : "R3 R5 opcode", 32'(eng_op), 32'(it.op));
          chk("R2 R3 bank", 32'(eng_bank), 32'(it.bank));
          @(negedge clk);
          chk("R11 request one cycle", 32'(eng_req), 32'd0);
          repeat (ENG_LAT) @(posedge clk);
          #1;
          eng_done = 1'b1; eng_rx = it.rx;
          @(posedge clk); #1;
          eng_done = 1'b0; eng_rx = 8'h00;
        end
      end
    end
  end

  // monitor: compares the status word the cycle after each completion
  initial begin
    logic        armed;
    logic [15:0] e;
    armed = 1'b0;
    forever begin
      @(negedge clk);
      if (armed) begin
        if (sts_exp_q.size() == 0) begin
          chk("R4 completion with none expected", 32'd1, 32'd0);
        end else begin
          e = sts_exp_q.pop_front();
          chk("R4 status after completion", 32'(status), 32'(e));
          chk("R8 irq after completion", 32'(irq), 32'(exp_irq(e)));
        end
      end
      armed = eng_done;
    end
  end

  logic finished = 1'b0;

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ctl_wr = 1'b0; ctl_wdata = '0;
    sts_wr = 1'b0; sts_wdata = '0;
    wr_done = 1'b0; burst_end = 1'b0; burst_bank = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset status", 32'(status), 32'd0);
    chk("R1 reset irq", 32'(irq), 32'd0);
    chk("R1 reset request", 32'(eng_req), 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2: status read of bank 0, transfer irq enabled
    issue(1'b1, 1'b0, 2'd0, 8'h83, 1'b1, 1'b0);
    wait_idle();
    check_now("R2 read bank0");

    // R7: clear everything
    sts_write(16'h0000);
    check_now("R7 clear all");

    // R3: write enable bank 2, irq disabled
    issue(1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 1'b0);
    wait_idle();
    check_now("R3 wren bank2");

    // R5: both commands together on bank 1
    issue(1'b1, 1'b1, 2'd1, 8'h1E, 1'b0, 1'b0);
    wait_idle();
    check_now("R5 both bank1");

    // R6: second command written while the first runs is dropped
    issue(1'b1, 1'b0, 2'd3, 8'h02, 1'b0, 1'b0);
    repeat (2) @(posedge clk);
    ctl_write({2'b00, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00});
    wait_idle();
    check_now("R6 busy write ignored");

    // R10: burst end on bank 1 clears only that bank
    pulse_burst_end(2'd1);
    check_now("R10 burst end bank1");

    // R8: enable only the write-complete interrupt
    wcie_m = 1'b1;
    tfie_m = 1'b0;
    ctl_write(16'h0200);
    check_now("R8 wcie only");

    // R9: write complete flag
    pulse_wr_done();
    check_now("R9 write complete");

    // R7: partial mask clears only bit 9
    sts_write(16'hFDFF);
    check_now("R7 mask bit9");

    sts_write(16'h0000);
    check_now("R7 final clear");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule